// File: doc/BRIEF.md
# Expansion Area Attribute Decoder

This block routes memory requests that fall in the 128 KB legacy expansion window, byte addresses 0C0000h to 0DFFFFh. The window is split into eight equal 16 KB segments. Each segment holds its own 2-bit attribute code, and that code decides whether a read or a write to it is served by DRAM or is handed on subtractively to the bridge/ISA side. Because the code is kept per segment and is direction-aware, a read and a write to the same address can go to different targets.

A request carries its address, its direction, its originator (host processor or a downstream link) and a snoop flag. A non-snooped request from a downstream link that hits the window always goes to DRAM, whatever the attribute says. Addresses outside the window raise a separate out-of-range flag and no route. The attribute register is loaded through a byte-enabled write port. Every decision is registered, so it appears one clock after the request.

Top module: `exp_area_decoder`

## Requirements
- R1: After reset all three outputs are low and every segment attribute is 00 (disabled), so a window request made before any configuration write goes to the bridge side.
- R2: A valid request whose address is outside 0C0000h..0DFFFFh (any upper address bit included) sets out_of_range_o and leaves to_dram_o and to_isa_o low.
- R3: Address bits [16:14] select the segment, and segment k uses attribute bits [2k+1:2k] of the register.
- R4: Attribute 00 (disabled) sends reads and writes to the bridge side (to_isa_o).
- R5: Attribute 11 (read/write) sends reads and writes to DRAM (to_dram_o).
- R6: Attribute 01 (read-only) sends reads to DRAM and writes to the bridge side.
- R7: Attribute 10 (write-only) sends writes to DRAM and reads to the bridge side.
- R8: A request with req_src_i = 1 (downstream link) and req_snoop_i = 0 that hits the window goes to DRAM whatever the attribute; a snooped link request and any host request (req_src_i = 0, snoop flag ignored) follow the attribute.
- R9: A configuration write updates attribute byte n (bits [8n+7:8n]) only when cfg_be_i[n] is 1; a write with no enable bit set changes nothing.
- R10: Outputs are registered: a request sampled at a clock edge shows its result right after that edge, at most one output is high, and all outputs are low after an edge without a valid request.
- R11: A request in the same cycle as a configuration write is decoded with the attribute value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Attribute register write strobe |
| cfg_be_i | input | 2 | Byte enables for the attribute write |
| cfg_wdata_i | input | 16 | Attribute write data, 2 bits per segment |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Request byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_src_i | input | 1 | 0 = host processor, 1 = downstream link |
| req_snoop_i | input | 1 | 1 = snooped request |
| to_dram_o | output | 1 | Request is served by DRAM |
| to_isa_o | output | 1 | Request passes subtractively to the bridge side |
| out_of_range_o | output | 1 | Request address lies outside the window |

## Verification
Each of the four attribute codes is tried with both a read and a write, so a swapped read-only and write-only decode, or a lost direction bit, shows up as a wrong target. Segment selection is probed by giving one segment a routing code and leaving its neighbour disabled, which separates a correct index from one shifted by a bit. The override is tried with all four combinations of originator and snoop flag against a disabled or read-only segment, and the addresses just below, just above and far above the window, together with its last byte, bracket the range test. Byte-lane writes, a write with no lane enabled, and a write coinciding with a request check the register path.

// File: rtl/exp_pkg.sv
package exp_pkg;
  localparam int unsigned NUM_SEG   = 8;
  localparam int unsigned ATTR_W    = 2;
  localparam int unsigned SEG_IDX_W = $clog2(NUM_SEG);
  localparam int unsigned CFG_W     = NUM_SEG * ATTR_W;
  localparam int unsigned BE_W      = CFG_W / 8;

  typedef enum logic [ATTR_W-1:0] {
    ATTR_OFF = 2'b00,
    ATTR_RD  = 2'b01,
    ATTR_WR  = 2'b10,
    ATTR_RW  = 2'b11
  } attr_e;

  typedef enum logic {
    SRC_HOST = 1'b0,
    SRC_LINK = 1'b1
  } src_e;
endpackage

// File: rtl/exp_attr_regs.sv
module exp_attr_regs
  import exp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] attr_o
);
  logic [7:0] lane_q [BE_W];

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                lane_q[l] <= '0;
      else if (we_i && be_i[l])   lane_q[l] <= wdata_i[l*8 +: 8];
    end
    assign attr_o[l*8 +: 8] = lane_q[l];
  end
endmodule

// File: rtl/exp_seg_decode.sv
module exp_seg_decode
  import exp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SEG_BYTES   = 16384,
  parameter logic [31:0] REGION_BASE = 32'h000C_0000
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 in_range_o,
  output logic [SEG_IDX_W-1:0] seg_idx_o
);
  localparam int unsigned OFS_W = $clog2(SEG_BYTES);
  localparam int unsigned TOP_L = OFS_W + SEG_IDX_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REGION_BASE);

  // window is naturally aligned, so a compare of the upper bits suffices
  assign in_range_o = (addr_i[ADDR_W-1:TOP_L] == BASE_A[ADDR_W-1:TOP_L]);
  assign seg_idx_o  = addr_i[TOP_L-1:OFS_W];

  logic unused_ofs;
  assign unused_ofs = ^{addr_i[OFS_W-1:0], BASE_A[TOP_L-1:0]};
endmodule

// File: rtl/exp_route.sv
module exp_route
  import exp_pkg::*;
(
  input  logic [CFG_W-1:0]     attr_i,
  input  logic [SEG_IDX_W-1:0] seg_idx_i,
  input  logic                 in_range_i,
  input  logic                 write_i,
  input  src_e                 src_i,
  input  logic                 snoop_i,
  output logic                 dram_o,
  output logic                 isa_o,
  output logic                 oor_o
);
  attr_e seg_attr;
  assign seg_attr = attr_e'(attr_i[seg_idx_i*ATTR_W +: ATTR_W]);

  always_comb begin
    dram_o = 1'b0;
    isa_o  = 1'b0;
    oor_o  = 1'b0;
    if (!in_range_i) begin
      oor_o = 1'b1;
    end else if (src_i == SRC_LINK && !snoop_i) begin
      dram_o = 1'b1;
    end else begin
      unique case (seg_attr)
        ATTR_OFF: isa_o  = 1'b1;
        ATTR_RD:  begin dram_o = !write_i; isa_o = write_i;  end
        ATTR_WR:  begin dram_o = write_i;  isa_o = !write_i; end
        ATTR_RW:  dram_o = 1'b1;
        default:  isa_o  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/exp_area_decoder.sv
module exp_area_decoder
  import exp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_src_i,
  input  logic              req_snoop_i,
  output logic              to_dram_o,
  output logic              to_isa_o,
  output logic              out_of_range_o
);
  logic [CFG_W-1:0]     attr_q;
  logic                 in_range;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic                 dram_d, isa_d, oor_d;

  exp_attr_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .attr_o  (attr_q)
  );

  exp_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (req_addr_i),
    .in_range_o (in_range),
    .seg_idx_o  (seg_idx)
  );

  exp_route u_route (
    .attr_i     (attr_q),
    .seg_idx_i  (seg_idx),
    .in_range_i (in_range),
    .write_i    (req_write_i),
    .src_i      (src_e'(req_src_i)),
    .snoop_i    (req_snoop_i),
    .dram_o     (dram_d),
    .isa_o      (isa_d),
    .oor_o      (oor_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_dram_o      <= 1'b0;
      to_isa_o       <= 1'b0;
      out_of_range_o <= 1'b0;
    end else begin
      to_dram_o      <= req_valid_i & dram_d;
      to_isa_o       <= req_valid_i & isa_d;
      out_of_range_o <= req_valid_i & oor_d;
    end
  end
endmodule

// File: rtl/exp_area_decoder_chk.sv
module exp_area_decoder_chk
  import exp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [BE_W-1:0]   cfg_be_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_src_i,
  input logic              req_snoop_i,
  input logic              to_dram_o,
  input logic              to_isa_o,
  input logic              out_of_range_o,
  input logic [CFG_W-1:0]  attr_q
);
  logic hit;
  assign hit = (req_addr_i >= ADDR_W'(32'h000C_0000)) && (req_addr_i <= ADDR_W'(32'h000D_FFFF));

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !to_dram_o && !to_isa_o && !out_of_range_o);

  p_outside_no_route_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit |=> out_of_range_o && !to_dram_o && !to_isa_o);

  p_link_nosnoop_dram_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && hit && req_src_i && !req_snoop_i |=> to_dram_o);

  p_no_lane_no_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_be_i == '0 |=> $stable(attr_q));

  p_one_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({to_dram_o, to_isa_o, out_of_range_o}));

  p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !to_dram_o && !to_isa_o && !out_of_range_o);

  p_valid_answers_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> $countones({to_dram_o, to_isa_o, out_of_range_o}) == 1);
endmodule

bind exp_area_decoder exp_area_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_we_i       (cfg_we_i),
  .cfg_be_i       (cfg_be_i),
  .req_valid_i    (req_valid_i),
  .req_addr_i     (req_addr_i),
  .req_src_i      (req_src_i),
  .req_snoop_i    (req_snoop_i),
  .to_dram_o      (to_dram_o),
  .to_isa_o       (to_isa_o),
  .out_of_range_o (out_of_range_o),
  .attr_q         (attr_q)
);

// File: tb/exp_area_decoder_tb.sv
module exp_area_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_be_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_src_i = 1'b0;
  logic        req_snoop_i = 1'b1;
  logic        to_dram_o, to_isa_o, out_of_range_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  exp_area_decoder u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_be_i, .cfg_wdata_i,
    .req_valid_i, .req_addr_i, .req_write_i, .req_src_i, .req_snoop_i,
    .to_dram_o, .to_isa_o, .out_of_range_o
  );

  // {tag[49:46], attr[45:30], addr[29:6], wr[5], link[4], snoop[3], exp{oor,dram,isa}[2:0]}
  localparam int NV = 18;
  localparam logic [49:0] VEC [NV] = '{
    {4'd4,  16'h0000, 24'h0C0000, 1'b0, 1'b0, 1'b1, 3'b001}, // R4 disabled read
    {4'd5,  16'hFFFF, 24'h0C0000, 1'b0, 1'b0, 1'b1, 3'b010}, // R5 rw read
    {4'd5,  16'hFFFF, 24'h0DFFFF, 1'b1, 1'b0, 1'b1, 3'b010}, // R5 rw write, last byte
    {4'd6,  16'h0001, 24'h0C1234, 1'b0, 1'b0, 1'b1, 3'b010}, // R6 ro read
    {4'd6,  16'h0001, 24'h0C1234, 1'b1, 1'b0, 1'b1, 3'b001}, // R6 ro write
    {4'd7,  16'h0002, 24'h0C2000, 1'b0, 1'b0, 1'b1, 3'b001}, // R7 wo read
    {4'd7,  16'h0002, 24'h0C2000, 1'b1, 1'b0, 1'b1, 3'b010}, // R7 wo write
    {4'd3,  16'hC000, 24'h0DC000, 1'b0, 1'b0, 1'b1, 3'b010}, // R3 seg7
    {4'd3,  16'hC000, 24'h0D8000, 1'b0, 1'b0, 1'b1, 3'b001}, // R3 seg6
    {4'd3,  16'h0030, 24'h0C8000, 1'b1, 1'b0, 1'b1, 3'b010}, // R3 seg2
    {4'd3,  16'h0030, 24'h0C4000, 1'b1, 1'b0, 1'b1, 3'b001}, // R3 seg1
    {4'd8,  16'h0000, 24'h0D0000, 1'b0, 1'b1, 1'b0, 3'b010}, // R8 link nosnoop disabled
    {4'd8,  16'h0001, 24'h0C0000, 1'b1, 1'b1, 1'b0, 3'b010}, // R8 link nosnoop write ro
    {4'd8,  16'h0000, 24'h0D0000, 1'b0, 1'b1, 1'b1, 3'b001}, // R8 link snooped
    {4'd8,  16'h0000, 24'h0D0000, 1'b0, 1'b0, 1'b0, 3'b001}, // R8 host nosnoop
    {4'd2,  16'hFFFF, 24'h0BFFFF, 1'b0, 1'b0, 1'b1, 3'b100}, // R2 below
    {4'd2,  16'hFFFF, 24'h0E0000, 1'b1, 1'b0, 1'b1, 3'b100}, // R2 above
    {4'd2,  16'hFFFF, 24'h1C0000, 1'b0, 1'b1, 1'b0, 3'b100}  // R2 upper bit
  };

  task automatic check(input int tag, input logic [2:0] exp_v);
    logic [2:0] act;
    act = {out_of_range_o, to_dram_o, to_isa_o};
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL R%0d: {oor,dram,isa} actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  task automatic do_cfg(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_be_i = '0;
  endtask

  task automatic do_req(input logic [31:0] a, input logic wr, input logic lk,
                        input logic sn, input int tag, input logic [2:0] exp_v);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr;
    req_src_i = lk; req_snoop_i = sn;
    @(posedge clk_i); #1;
    check(tag, exp_v);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check(1, 3'b000);                        // R1 outputs low in reset
    @(negedge clk_i) rst_ni = 1'b1;
    do_req(32'h000C_0000, 1'b0, 1'b0, 1'b1, 1, 3'b001); // R1 reset attr disabled
    do_req(32'h000D_C000, 1'b1, 1'b0, 1'b1, 1, 3'b001); // R1

    for (int i = 0; i < NV; i++) begin
      do_cfg(2'b11, VEC[i][45:30]);
      do_req({8'h00, VEC[i][29:6]}, VEC[i][5], VEC[i][4], VEC[i][3],
             int'(VEC[i][49:46]), VEC[i][2:0]);
    end

    // R9 byte lanes
    do_cfg(2'b11, 16'hFFFF);
    do_cfg(2'b01, 16'h0000);
    do_req(32'h000C_0000, 1'b0, 1'b0, 1'b1, 9, 3'b001); // R9 low lane cleared
    do_req(32'h000D_0000, 1'b0, 1'b0, 1'b1, 9, 3'b010); // R9 high lane kept
    do_cfg(2'b00, 16'h0000);
    do_req(32'h000D_0000, 1'b1, 1'b0, 1'b1, 9, 3'b010); // R9 no lane, no change
    do_cfg(2'b10, 16'h0000);
    do_req(32'h000D_0000, 1'b1, 1'b0, 1'b1, 9, 3'b001); // R9 high lane cleared

    // R10 idle edge gives no output
    @(negedge clk_i); req_addr_i = 32'h000C_0000;
    @(posedge clk_i); #1 check(10, 3'b000);

    // R11 write and request in the same cycle: old attributes apply
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_be_i = 2'b11; cfg_wdata_i = 16'hFFFF;
    req_valid_i = 1'b1; req_addr_i = 32'h000C_0000; req_write_i = 1'b0;
    req_src_i = 1'b0; req_snoop_i = 1'b1;
    @(posedge clk_i); #1 check(11, 3'b001);
    @(negedge clk_i); cfg_we_i = 1'b0; cfg_be_i = '0;
    @(posedge clk_i); #1 check(11, 3'b010);     // R11 new value next cycle
    @(negedge clk_i); req_valid_i = 1'b0;
    @(posedge clk_i); #1 check(10, 3'b000);     // R10 falls after valid drops

    repeat (2) @(posedge clk_i);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule